// File: doc/BRIEF.md
# Reader Frame Byte Buffer with Transmit Length Tracking

This block sits between a host controller and the framing logic of a contactless reader. It holds up to twelve bytes in a FIFO that carries data in one direction at a time. When transmitting, the host writes bytes and the framer takes them. When receiving, the framer deposits bytes and the host drains them. Frames may be longer than the FIFO, so the host keeps refilling or emptying it while a frame is in progress. A registered interrupt request asks the host for service when the FIFO runs low during transmit or fills up during receive.

To start a transmit frame, the host pulses `arm` with a whole-byte count and a broken-byte bit count. The first byte the host writes after that starts the frame. A frame counter then follows the bytes handed to the framer. It flags the final byte, gives that byte's number of valid bits, and pulses `eof` once the frame is complete. A status byte shows a sticky overflow flag and the two watermark flags. `fifo_reset` returns the buffer, the frame logic and the interrupt to their idle state.

All data crossing the block uses valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. The framer receive port is back-pressured by `fr_rx_ready`, which drops while the FIFO is full. The host write port never stalls: `host_wready` is high whenever the direction is transmit. A byte written while the FIFO is full is discarded and flagged, not held back. The outgoing ports (`host_rvalid`, `fr_tx_valid`) only offer a byte that is actually stored.

Top module: `rfb_frame_buf`

## Requirements
- R1: The FIFO keeps at most 12 bytes and returns them in write order. In transmit direction (`dir_rx`=0) `host_wready` is 1, and a host write while 12 bytes are held is discarded.
- R2: A push and a pop in the same cycle leave the FIFO occupancy unchanged.
- R3: A frame becomes active (`tx_active`=1, framer may take bytes) on the first accepted host write after an `arm` pulse. Without a preceding `arm`, host writes do not start a frame.
- R4: For length L bytes and broken-byte count B, the frame carries L+1 bytes when B is nonzero and L bytes when B is zero. `fr_tx_last` is 1 only on the final byte. `fr_tx_nbits` is 8 when B is 0 and B otherwise.
- R5: `eof` pulses high for one cycle, in the cycle after the final byte is taken by the framer. For a zero-length frame (L=0, B=0), it pulses in the cycle after the starting host write, and the frame never becomes active.
- R6: Bit 4 of `status_byte` is the overflow flag. It sets in the cycle after a discarded write, stays set until `status_rd` or `fifo_reset`, and is cleared one cycle after either.
- R7: Bit 5 of `status_byte` is the low flag: 1 while a frame is active and the occupancy is 3 or less.
- R8: Bit 6 of `status_byte` is the high flag: 1 in receive direction (`dir_rx`=1) while the occupancy is 9 or more.
- R9: `irq` is registered. It is 1 in the cycle after one in which either a frame was active with occupancy below 3, or the direction was receive with occupancy above 9. Otherwise it is 0.
- R10: In receive direction, `fr_rx_ready` is 1 exactly when fewer than 12 bytes are held, and `host_rvalid` is 1 exactly when the FIFO is not empty.
- R11: `fifo_reset` empties the FIFO and clears the frame counter, the armed state, `tx_active`, `irq` and the overflow flag, all visible in the next cycle.
- R12: Bits 7 and 3..0 of `status_byte` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | Data direction: 0 transmit, 1 receive |
| arm | input | 1 | Pulse: latch frame length and wait for the first byte |
| fifo_reset | input | 1 | Pulse: flush the FIFO and frame state |
| tx_len_bytes | input | 12 | Whole-byte count of the frame |
| tx_len_bits | input | 4 | Valid bits in a final partial byte (0 = none) |
| host_wdata | input | 8 | Host write byte |
| host_wvalid | input | 1 | Host write valid |
| host_wready | output | 1 | Host write ready (high in transmit direction) |
| host_rdata | output | 8 | Host read byte |
| host_rvalid | output | 1 | Host read valid |
| host_rready | input | 1 | Host read ready |
| fr_tx_data | output | 8 | Byte offered to the framer |
| fr_tx_valid | output | 1 | Framer transmit valid |
| fr_tx_ready | input | 1 | Framer transmit ready |
| fr_tx_last | output | 1 | Offered byte is the final byte of the frame |
| fr_tx_nbits | output | 4 | Valid bits in the offered byte when it is the last one |
| fr_rx_data | input | 8 | Byte from the framer |
| fr_rx_valid | input | 1 | Framer receive valid |
| fr_rx_ready | output | 1 | Framer receive ready |
| tx_active | output | 1 | A transmit frame is in progress |
| eof | output | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Host service request |
| status_rd | input | 1 | Status read strobe, clears overflow |
| status_byte | output | 8 | Status flags |

## Verification
The assertions assume that the direction input changes only while the FIFO is empty and no frame is active. They also assume that `arm` is never raised in the same cycle as a host write, and that the framer receive port is used only in receive direction. The stimulus drives every input on the falling edge and changes `dir_rx` only right after a `fifo_reset`. It arms a frame only while the block is idle and keeps the host write and framer ports quiet in the direction that does not use them. Together these keep every run inside the conditions the properties rely on.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

  // positions inside the status byte
  localparam int unsigned ST_OVF  = 4;
  localparam int unsigned ST_LOW  = 5;
  localparam int unsigned ST_HIGH = 6;
endpackage

// File: rtl/rfb_fifo.sv
module rfb_fifo #(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  rfb_pkg::byte_t       push_data,
  input  logic                 pop,
  output rfb_pkg::byte_t       pop_data,
  output logic [OCC_W-1:0]     occ,
  output logic                 full,
  output logic                 empty
);
  rfb_pkg::byte_t   mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (occ == OCC_W'(DEPTH));
  assign empty    = (occ == '0);
endmodule

// File: rtl/rfb_len_track.sv
module rfb_len_track #(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned BB_W  = 4,
  localparam int unsigned CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             arm,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic [BB_W-1:0]  len_bits,
  input  logic             start_wr,
  input  logic             beat,
  output logic             active,
  output logic             last,
  output logic [BB_W-1:0]  nbits,
  output logic             eof
);
  logic             armed_q;
  logic [CNT_W-1:0] total_q, sent_q;
  logic [BB_W-1:0]  bits_q;
  logic [CNT_W-1:0] total_d;

  // a nonzero partial-bit count adds one trailing byte
  assign total_d = CNT_W'(len_bytes) + CNT_W'(len_bits != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      active  <= 1'b0;
      eof     <= 1'b0;
      sent_q  <= '0;
      total_q <= '0;
      bits_q  <= '0;
    end else if (clr) begin
      armed_q <= 1'b0;
      active  <= 1'b0;
      eof     <= 1'b0;
      sent_q  <= '0;
      total_q <= '0;
      bits_q  <= '0;
    end else begin
      eof <= 1'b0;
      if (arm) begin
        armed_q <= 1'b1;
        active  <= 1'b0;
        sent_q  <= '0;
        total_q <= total_d;
        bits_q  <= len_bits;
      end else if (armed_q && start_wr) begin
        armed_q <= 1'b0;
        if (total_q == '0) eof    <= 1'b1;
        else               active <= 1'b1;
      end else if (active && beat) begin
        sent_q <= sent_q + 1'b1;
        if (last) begin
          active <= 1'b0;
          eof    <= 1'b1;
        end
      end
    end
  end

  assign last  = active && (sent_q == total_q - CNT_W'(1));
  assign nbits = (bits_q == '0) ? BB_W'(8) : bits_q;
endmodule

// File: rtl/rfb_flags.sv
module rfb_flags #(
  parameter int unsigned OCC_W     = 4,
  parameter int unsigned LOW_MARK  = 3,
  parameter int unsigned HIGH_MARK = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dir_rx,
  input  logic             active,
  input  logic [OCC_W-1:0] occ,
  input  logic             ovf_set,
  input  logic             stat_rd,
  output logic [7:0]       status,
  output logic             irq
);
  logic ovf_q, low_lvl, high_lvl, want_irq;

  assign low_lvl  = active && (occ <= OCC_W'(LOW_MARK));
  assign high_lvl = dir_rx && (occ >= OCC_W'(HIGH_MARK));
  assign want_irq = (active && (occ < OCC_W'(LOW_MARK))) ||
                    (dir_rx && (occ > OCC_W'(HIGH_MARK)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      irq   <= 1'b0;
    end else if (clr) begin
      ovf_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= want_irq;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (stat_rd) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    status                   = '0;
    status[rfb_pkg::ST_OVF]  = ovf_q;
    status[rfb_pkg::ST_LOW]  = low_lvl;
    status[rfb_pkg::ST_HIGH] = high_lvl;
  end
endmodule

// File: rtl/rfb_frame_buf.sv
module rfb_frame_buf #(
  parameter int unsigned DEPTH     = 12,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned BB_W      = 4,
  parameter int unsigned LOW_MARK  = 3,
  parameter int unsigned HIGH_MARK = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rx,
  input  logic             arm,
  input  logic             fifo_reset,
  input  logic [LEN_W-1:0] tx_len_bytes,
  input  logic [BB_W-1:0]  tx_len_bits,
  input  logic [7:0]       host_wdata,
  input  logic             host_wvalid,
  output logic             host_wready,
  output logic [7:0]       host_rdata,
  output logic             host_rvalid,
  input  logic             host_rready,
  output logic [7:0]       fr_tx_data,
  output logic             fr_tx_valid,
  input  logic             fr_tx_ready,
  output logic             fr_tx_last,
  output logic [BB_W-1:0]  fr_tx_nbits,
  input  logic [7:0]       fr_rx_data,
  input  logic             fr_rx_valid,
  output logic             fr_rx_ready,
  output logic             tx_active,
  output logic             eof,
  output logic             irq,
  input  logic             status_rd,
  output logic [7:0]       status_byte
);
  import rfb_pkg::*;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  dir_e             dir;
  logic             push, pop, full, empty, host_wr, beat;
  byte_t            push_data, pop_data;
  logic [OCC_W-1:0] occ;

  assign dir         = dir_e'(dir_rx);
  assign host_wready = (dir == DIR_TX);
  assign host_wr     = host_wvalid && host_wready;
  assign fr_rx_ready = (dir == DIR_RX) && !full;
  assign host_rvalid = (dir == DIR_RX) && !empty;
  assign fr_tx_valid = (dir == DIR_TX) && tx_active && !empty;
  assign beat        = fr_tx_valid && fr_tx_ready;

  assign push      = (dir == DIR_RX) ? (fr_rx_valid && fr_rx_ready) : (host_wr && !full);
  assign push_data = (dir == DIR_RX) ? fr_rx_data : host_wdata;
  assign pop       = (host_rvalid && host_rready) || beat;

  assign host_rdata = pop_data;
  assign fr_tx_data = pop_data;

  rfb_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_reset),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .pop_data  (pop_data),
    .occ       (occ),
    .full      (full),
    .empty     (empty)
  );

  rfb_len_track #(.LEN_W(LEN_W), .BB_W(BB_W)) len_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_reset),
    .arm       (arm),
    .len_bytes (tx_len_bytes),
    .len_bits  (tx_len_bits),
    .start_wr  (host_wr && !full),
    .beat      (beat),
    .active    (tx_active),
    .last      (fr_tx_last),
    .nbits     (fr_tx_nbits),
    .eof       (eof)
  );

  rfb_flags #(.OCC_W(OCC_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_reset),
    .dir_rx  (dir_rx),
    .active  (tx_active),
    .occ     (occ),
    .ovf_set (host_wr && full),
    .stat_rd (status_rd),
    .status  (status_byte),
    .irq     (irq)
  );
endmodule

// File: rtl/rfb_frame_buf_chk.sv
module rfb_frame_buf_chk #(
  parameter int unsigned DEPTH    = 12,
  parameter int unsigned LOW_MARK = 3,
  localparam int unsigned OCC_W   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_reset,
  input logic             dir_rx,
  input logic             host_wvalid,
  input logic             status_rd,
  input logic             push,
  input logic             pop,
  input logic [OCC_W-1:0] occ,
  input logic             full,
  input logic [7:0]       status_byte,
  input logic             irq,
  input logic             tx_active,
  input logic             eof,
  input logic             fr_tx_valid,
  input logic             fr_tx_ready,
  input logic             fr_tx_last
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R1
  AST_OCC_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !fifo_reset) |=> (occ == $past(occ) + 1'b1)); // R1
  AST_OCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !fifo_reset) |=> $stable(occ)); // R2
  AST_EOF_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_tx_valid && fr_tx_ready && fr_tx_last && !fifo_reset) |=> eof); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wvalid && !dir_rx && full && !fifo_reset) |=> status_byte[rfb_pkg::ST_OVF]); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[rfb_pkg::ST_OVF] && !status_rd && !fifo_reset) |=> status_byte[rfb_pkg::ST_OVF]); // R6
  AST_IRQ_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && (occ < OCC_W'(LOW_MARK)) && !fifo_reset) |=> irq); // R9
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (occ == '0 && !irq && !tx_active && !status_byte[rfb_pkg::ST_OVF])); // R11
endmodule

bind rfb_frame_buf rfb_frame_buf_chk #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_reset  (fifo_reset),
  .dir_rx      (dir_rx),
  .host_wvalid (host_wvalid),
  .status_rd   (status_rd),
  .push        (push),
  .pop         (pop),
  .occ         (occ),
  .full        (full),
  .status_byte (status_byte),
  .irq         (irq),
  .tx_active   (tx_active),
  .eof         (eof),
  .fr_tx_valid (fr_tx_valid),
  .fr_tx_ready (fr_tx_ready),
  .fr_tx_last  (fr_tx_last)
);

// File: tb/rfb_frame_buf_tb_top.sv
`timescale 1ns/1ps
module rfb_frame_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rx = 1'b0, arm = 1'b0, fifo_reset = 1'b0;
  logic [11:0] tx_len_bytes = '0;
  logic [3:0]  tx_len_bits = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wvalid = 1'b0, host_rready = 1'b0;
  logic        fr_tx_ready = 1'b0, fr_rx_valid = 1'b0, status_rd = 1'b0;
  logic [7:0]  fr_rx_data = '0;
  logic        host_wready, host_rvalid, fr_tx_valid, fr_tx_last, fr_rx_ready;
  logic        tx_active, eof, irq;
  logic [7:0]  host_rdata, fr_tx_data, status_byte;
  logic [3:0]  fr_tx_nbits;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rfb_frame_buf dut_i (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .arm(arm), .fifo_reset(fifo_reset),
    .tx_len_bytes(tx_len_bytes), .tx_len_bits(tx_len_bits),
    .host_wdata(host_wdata), .host_wvalid(host_wvalid), .host_wready(host_wready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_rready(host_rready),
    .fr_tx_data(fr_tx_data), .fr_tx_valid(fr_tx_valid), .fr_tx_ready(fr_tx_ready),
    .fr_tx_last(fr_tx_last), .fr_tx_nbits(fr_tx_nbits),
    .fr_rx_data(fr_rx_data), .fr_rx_valid(fr_rx_valid), .fr_rx_ready(fr_rx_ready),
    .tx_active(tx_active), .eof(eof), .irq(irq),
    .status_rd(status_rd), .status_byte(status_byte)
  );

  // {pop, last, byte, status}: pop=0 host write of byte, pop=1 framer take expecting byte
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 1'b0, 8'hA0, 8'h20}, {1'b0, 1'b0, 8'hA1, 8'h20},
    {1'b0, 1'b0, 8'hA2, 8'h20}, {1'b0, 1'b0, 8'hA3, 8'h00},
    {1'b0, 1'b0, 8'hA4, 8'h00}, {1'b1, 1'b0, 8'hA0, 8'h00},
    {1'b1, 1'b0, 8'hA1, 8'h20}, {1'b1, 1'b0, 8'hA2, 8'h20},
    {1'b1, 1'b0, 8'hA3, 8'h20}, {1'b1, 1'b1, 8'hA4, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start just after a falling edge and return on the next one
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm(input int len, input int bits);
    tx_len_bytes = 12'(len); tx_len_bits = 4'(bits); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic do_flush();
    fifo_reset = 1'b1; @(negedge clk); fifo_reset = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] b);
    host_wdata = b; host_wvalid = 1'b1;
    @(negedge clk); host_wvalid = 1'b0;
  endtask

  task automatic fr_take(output logic v, output logic [7:0] d, output logic l, output logic [3:0] nb);
    v = fr_tx_valid; d = fr_tx_data; l = fr_tx_last; nb = fr_tx_nbits;
    fr_tx_ready = 1'b1; @(negedge clk); fr_tx_ready = 1'b0;
  endtask

  task automatic fr_push(input logic [7:0] b);
    fr_rx_data = b; fr_rx_valid = 1'b1;
    @(negedge clk); fr_rx_valid = 1'b0;
  endtask

  task automatic host_read(output logic v, output logic [7:0] d);
    v = host_rvalid; d = host_rdata;
    host_rready = 1'b1; @(negedge clk); host_rready = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       v, l;
    logic [7:0] d;
    logic [3:0] nb;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    check("R12 reset status", status_byte, 8'h00);
    check("R9 reset irq", irq, 0);
    check("R3 reset idle", tx_active, 0);
    check("R1 wready in tx", host_wready, 1);

    // table: 5-byte frame streamed through
    do_arm(5, 0);
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][17] == 1'b0) begin
        host_write(VEC[i][15:8]);
        if (i == 0) check("R3 start on first write", tx_active, 1);
      end else begin
        fr_take(v, d, l, nb);
        check("R1 take valid", v, 1);
        check("R1 order", d, VEC[i][15:8]);
        check("R4 last flag", l, VEC[i][16]);
        if (VEC[i][16]) check("R4 full last byte bits", nb, 8);
      end
      check("R7 status", status_byte, VEC[i][7:0]);
    end
    check("R5 eof after last", eof, 1);
    idle(1);
    check("R5 eof single cycle", eof, 0);
    check("R4 frame ended", tx_active, 0);

    // no start without arm, then flush drops the stray byte
    host_write(8'h11);
    check("R3 no start unarmed", tx_active, 0);
    check("R3 no take unarmed", fr_tx_valid, 0);
    do_flush();
    do_arm(1, 0);
    host_write(8'h22);
    fr_take(v, d, l, nb);
    check("R11 flush dropped old byte", d, 8'h22);
    check("R4 single-byte last", l, 1);
    idle(1);

    // interrupt during transmit and simultaneous push/pop
    do_arm(6, 0);
    host_write(8'h30);
    check("R9 irq registered lag", irq, 0);
    idle(1);
    check("R9 irq low occupancy", irq, 1);
    host_write(8'h31); host_write(8'h32); host_write(8'h33);
    check("R9 irq after occ 3", irq, 0);
    host_wdata = 8'h34; host_wvalid = 1'b1;
    fr_take(v, d, l, nb);
    host_wvalid = 1'b0;
    check("R2 both data", d, 8'h30);
    check("R2 occupancy kept", status_byte, 8'h00);
    host_wdata = 8'h35; host_wvalid = 1'b1;
    fr_take(v, d, l, nb);
    host_wvalid = 1'b0;
    check("R2 occupancy kept again", status_byte, 8'h00);
    fr_take(v, d, l, nb);
    check("R7 low at three", status_byte, 8'h20);
    fr_take(v, d, l, nb);
    fr_take(v, d, l, nb);
    check("R2 pushed byte kept", d, 8'h34);
    fr_take(v, d, l, nb);
    check("R2 final data", d, 8'h35);
    check("R4 last of six", l, 1);
    idle(1);

    // broken final byte
    do_arm(2, 3);
    host_write(8'h40); host_write(8'h41); host_write(8'h42);
    fr_take(v, d, l, nb);
    check("R4 not last 1", l, 0);
    fr_take(v, d, l, nb);
    check("R4 not last 2", l, 0);
    fr_take(v, d, l, nb);
    check("R4 partial last", l, 1);
    check("R4 partial bits", nb, 3);
    check("R5 eof partial", eof, 1);
    idle(1);

    // overflow, sticky, cleared by status read
    do_flush();
    do_arm(20, 0);
    for (int i = 0; i < 12; i++) host_write(8'h50 + 8'(i));
    check("R6 full no overflow", status_byte, 8'h00);
    host_write(8'h99);
    check("R6 overflow set", status_byte, 8'h10);
    idle(2);
    check("R6 overflow sticky", status_byte, 8'h10);
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    check("R6 cleared by read", status_byte, 8'h00);
    for (int i = 0; i < 12; i++) begin
      fr_take(v, d, l, nb);
      check("R1 order after overflow", d, 8'h50 + 8'(i));
    end
    check("R1 dropped byte absent", fr_tx_valid, 0);
    idle(1);
    check("R9 irq when drained", irq, 1);
    do_flush();
    check("R11 irq cleared", irq, 0);
    check("R11 frame cleared", tx_active, 0);

    // overflow cleared by flush
    do_arm(20, 0);
    for (int i = 0; i < 13; i++) host_write(8'h60);
    check("R6 overflow again", status_byte[4], 1);
    do_flush();
    check("R11 overflow cleared", status_byte, 8'h00);

    // receive direction
    dir_rx = 1'b1;
    idle(1);
    check("R10 no host write in rx", host_wready, 0);
    check("R10 empty rvalid", host_rvalid, 0);
    for (int i = 0; i < 8; i++) fr_push(8'h70 + 8'(i));
    check("R8 below high", status_byte, 8'h00);
    fr_push(8'h78);
    check("R8 high at nine", status_byte, 8'h40);
    fr_push(8'h79);
    check("R9 rx irq lag", irq, 0);
    idle(1);
    check("R9 rx irq above nine", irq, 1);
    fr_push(8'h7A); fr_push(8'h7B);
    check("R10 full back-pressure", fr_rx_ready, 0);
    fr_push(8'hEE);
    for (int i = 0; i < 12; i++) begin
      host_read(v, d);
      check("R10 read order", d, 8'h70 + 8'(i));
    end
    check("R10 drained", host_rvalid, 0);
    check("R1 blocked byte absent", status_byte, 8'h00);
    idle(1);
    check("R9 irq off rx", irq, 0);
    do_flush();
    dir_rx = 1'b0;

    // zero-length frame
    do_arm(0, 0);
    host_write(8'h77);
    check("R5 zero-length eof", eof, 1);
    check("R5 zero-length inactive", tx_active, 0);
    idle(1);
    check("R5 zero-length eof ends", eof, 0);
    do_flush();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule